// File: doc/BRIEF.md
# Programmable Input Glitch Filter

This block cleans up one already-synchronized input line before it reaches edge or level detection. It removes pulses that are shorter than a programmed timeout. A small configuration set controls it: a two-bit filter type, a four-bit timeout count, and two bits that select the time value of one count. The filter type decides which level changes must be held stable before they are accepted. It can be rising changes, falling changes or both. Changes in the other direction are passed on at once. When the filter type is zero, the line is copied through with one register of delay.

All timing comes from a slow tick-enable input, for example a 32.768 kHz strobe in the core clock domain. The timeout is the count multiplied by a unit. The unit is 2, 8, 512 or 2048 ticks by default, selected by a "long" bit and a "coarse" bit. The input, the output and the configuration are plain levels. There is no handshake, and the output is valid in every cycle.

Top module: `debounce_filter`

## Requirements
- R1: While reset is asserted, the output is 0 whatever the input, and no pending count survives into the first cycle after reset.
- R2: With filter type 0, the output equals the input as sampled at the previous clock edge.
- R3: The filter type selects which directions are filtered. Type 1 filters both directions. Type 2 filters only 0-to-1 changes, so high pulses are removed and low pulses are kept. Type 3 filters only 1-to-0 changes. While a filtered change is pending, the output holds its old level.
- R4: The timeout T in ticks is count × unit. With {long,coarse} = 00 the unit is 2 ticks, 01 gives 8, 10 gives 512 and 11 gives 2048. A count of 0 gives T = 1. A filtered change reaches the output at the clock edge that samples the T-th tick seen while the input has differed from the output.
- R5: If the input returns to the output level before the timeout, the change is dropped. A later attempt needs the full T again.
- R6: In types 2 and 3, a change in the unfiltered direction reaches the output at the next clock edge.
- R7: In a cycle where the effective configuration differs from the one in the previous cycle, the output holds and the tick counts are cleared. The new rules apply from the following edge.
- R8: With filter type 0, the effective timeout count and unit bits are zero. Changing them while the type is 0 is therefore not a configuration change, and pass-through continues without a hold cycle.
- R9: Time advances only on cycles with tick high. Without ticks, a pending filtered change never completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle timebase strobe |
| din | input | 1 | Synchronized raw input level |
| cfg_type | input | 2 | Filter type: 0 off, 1 both, 2 rising only, 3 falling only |
| cfg_long | input | 1 | Selects the long unit pair |
| cfg_coarse | input | 1 | Selects the larger unit of the pair |
| cfg_count | input | CNT_W | Timeout count in units |
| dout | output | 1 | Filtered level |

## Verification
Three events can fall in the same cycle: a configuration change, the expiry of a pending timeout, and an immediate pass in the unfiltered direction. To provoke the clash, the bench changes the timeout count on exactly the cycle whose edge would complete a pending change. In a second case it changes the count together with an unfiltered input change. In both cases the bench expects the output to hold for that edge. It then expects the change to arrive after one more cycle for a pass, or after a full new timeout counted from the next edge for an expiry. The bench sweeps every count with both short units for every filter type and direction, and computes each expected edge arithmetically.

// File: rtl/dbf_pkg.sv
package dbf_pkg;

  // Filter type encoding on the configuration input.
  typedef enum logic [1:0] {
    FT_OFF       = 2'd0,  // transparent, one register of delay
    FT_BOTH      = 2'd1,  // both directions must be held stable
    FT_RISE_ONLY = 2'd2,  // only 0->1 is delayed (high pulses removed)
    FT_FALL_ONLY = 2'd3   // only 1->0 is delayed (low pulses removed)
  } ftype_e;

  // Whether a change toward level 'to_high' is subject to the timeout.
  function automatic logic dir_filtered(ftype_e ft, logic to_high);
    case (ft)
      FT_BOTH:      return 1'b1;
      FT_RISE_ONLY: return to_high;
      FT_FALL_ONLY: return ~to_high;
      default:      return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/dbf_cfg.sv
// Normalizes the configuration and flags any change against the previous cycle.
module dbf_cfg
  import dbf_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       in_type,
  input  logic             in_long,
  input  logic             in_coarse,
  input  logic [CNT_W-1:0] in_count,
  output ftype_e           eff_type,
  output logic             eff_long,
  output logic             eff_coarse,
  output logic [CNT_W-1:0] eff_count,
  output logic             cfg_chg
);

  logic             off;
  ftype_e           prev_type;
  logic             prev_long;
  logic             prev_coarse;
  logic [CNT_W-1:0] prev_count;

  // With the filter off, every timing field reads as zero.
  always_comb begin
    off        = (in_type == 2'd0);
    eff_type   = ftype_e'(in_type);
    eff_long   = off ? 1'b0 : in_long;
    eff_coarse = off ? 1'b0 : in_coarse;
    eff_count  = off ? '0 : in_count;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_type   <= FT_OFF;
      prev_long   <= 1'b0;
      prev_coarse <= 1'b0;
      prev_count  <= '0;
    end else begin
      prev_type   <= eff_type;
      prev_long   <= eff_long;
      prev_coarse <= eff_coarse;
      prev_count  <= eff_count;
    end
  end

  assign cfg_chg = (eff_type != prev_type) || (eff_long != prev_long) ||
                   (eff_coarse != prev_coarse) || (eff_count != prev_count);

  // R8: with the type held at off, no change is ever flagged.
  a_r8_off_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_type == FT_OFF) |=> ((eff_type == FT_OFF) |-> !cfg_chg));

endmodule

// File: rtl/dbf_prescaler.sv
// Divides timebase ticks into unit pulses; restarts whenever cleared.
module dbf_prescaler #(
  parameter int U_SHORT_FINE   = 2,
  parameter int U_SHORT_COARSE = 8,
  parameter int U_LONG_FINE    = 512,
  parameter int U_LONG_COARSE  = 2048,
  parameter int PRE_W          = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  input  logic sel_long,
  input  logic sel_coarse,
  output logic unit_pulse
);

  logic [PRE_W-1:0] pre;
  logic [PRE_W-1:0] lim;

  always_comb begin
    case ({sel_long, sel_coarse})
      2'b00:   lim = PRE_W'(U_SHORT_FINE - 1);
      2'b01:   lim = PRE_W'(U_SHORT_COARSE - 1);
      2'b10:   lim = PRE_W'(U_LONG_FINE - 1);
      default: lim = PRE_W'(U_LONG_COARSE - 1);
    endcase
  end

  assign unit_pulse = tick && (pre == lim);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) pre <= '0;
    else if (tick)     pre <= (pre == lim) ? '0 : pre + 1'b1;
  end

  // R4: the tick count never passes the selected unit length.
  a_r4_pre_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |-> (pre <= lim));

  // R9: a unit boundary needs a tick.
  a_r9_pulse_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    unit_pulse |-> tick);

endmodule

// File: rtl/dbf_stab_counter.sv
// Counts whole units of stability and signals expiry of the timeout.
module dbf_stab_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             unit_pulse,
  input  logic [CNT_W-1:0] count,
  output logic             expire
);

  logic [CNT_W-1:0] units;
  logic             zero_cnt;

  assign zero_cnt = (count == '0);

  // A zero count completes on the first tick; otherwise on the last unit.
  always_comb begin
    if (!run)          expire = 1'b0;
    else if (zero_cnt) expire = tick;
    else               expire = unit_pulse && (units == CNT_W'(count - 1'b1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !run || expire) units <= '0;
    else if (unit_pulse)          units <= units + 1'b1;
  end

  // R4: the unit count stays below the programmed count while running.
  a_r4_units_below_count: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !zero_cnt) |-> (units < count));

  // R9: expiry only ever happens on a tick.
  a_r9_expire_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> tick);

endmodule

// File: rtl/debounce_filter.sv
// Per-pin programmable glitch filter.
module debounce_filter
  import dbf_pkg::*;
#(
  parameter int CNT_W          = 4,
  parameter int U_SHORT_FINE   = 2,
  parameter int U_SHORT_COARSE = 8,
  parameter int U_LONG_FINE    = 512,
  parameter int U_LONG_COARSE  = 2048
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             din,
  input  logic [1:0]       cfg_type,
  input  logic             cfg_long,
  input  logic             cfg_coarse,
  input  logic [CNT_W-1:0] cfg_count,
  output logic             dout
);

  localparam int UMAX_S = (U_SHORT_FINE > U_SHORT_COARSE) ? U_SHORT_FINE : U_SHORT_COARSE;
  localparam int UMAX_L = (U_LONG_FINE > U_LONG_COARSE) ? U_LONG_FINE : U_LONG_COARSE;
  localparam int UMAX   = (UMAX_S > UMAX_L) ? UMAX_S : UMAX_L;
  localparam int PRE_W  = (UMAX > 2) ? $clog2(UMAX) : 1;

  ftype_e           eff_type;
  logic             eff_long;
  logic             eff_coarse;
  logic [CNT_W-1:0] eff_count;
  logic             cfg_chg;
  logic             mism;
  logic             pend;
  logic             pass;
  logic             run;
  logic             unit_pulse;
  logic             expire;
  logic             dout_q;

  dbf_cfg #(.CNT_W(CNT_W)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_type    (cfg_type),
    .in_long    (cfg_long),
    .in_coarse  (cfg_coarse),
    .in_count   (cfg_count),
    .eff_type   (eff_type),
    .eff_long   (eff_long),
    .eff_coarse (eff_coarse),
    .eff_count  (eff_count),
    .cfg_chg    (cfg_chg)
  );

  // Direction decision: a mismatch is either pending (timed) or passed now.
  always_comb begin
    mism = (din != dout_q);
    pend = mism && dir_filtered(eff_type, din);
    pass = mism && !dir_filtered(eff_type, din);
    run  = pend && !cfg_chg;
  end

  dbf_prescaler #(
    .U_SHORT_FINE   (U_SHORT_FINE),
    .U_SHORT_COARSE (U_SHORT_COARSE),
    .U_LONG_FINE    (U_LONG_FINE),
    .U_LONG_COARSE  (U_LONG_COARSE),
    .PRE_W          (PRE_W)
  ) u_pre (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (!run || expire),
    .tick       (tick),
    .sel_long   (eff_long),
    .sel_coarse (eff_coarse),
    .unit_pulse (unit_pulse)
  );

  dbf_stab_counter #(.CNT_W(CNT_W)) u_stab (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .tick       (tick),
    .unit_pulse (unit_pulse),
    .count      (eff_count),
    .expire     (expire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                    dout_q <= 1'b0;
    else if (cfg_chg)              dout_q <= dout_q;
    else if (pass || expire)       dout_q <= din;
  end

  assign dout = dout_q;

  // R7: a configuration change freezes the output for that edge.
  a_r7_hold_on_change: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_chg |=> (dout == $past(dout)));

  // R2: filter off gives a one-register copy of the input.
  a_r2_off_copy: assert property (@(posedge clk) disable iff (!rst_n)
    ((eff_type == FT_OFF) && !cfg_chg) |=> (dout == $past(din)));

  // R6: the unfiltered direction passes at the next edge.
  a_r6_fast_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (pass && !cfg_chg) |=> (dout == $past(din)));

  // R3 / R5: a pending change that has not expired leaves the output alone.
  a_r5_hold_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !expire) |=> $stable(dout));

endmodule

// File: tb/test_debounce_filter.sv
module test_debounce_filter;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick;
  logic       din;
  logic [1:0] ftype;
  logic       lng;
  logic       crs;
  logic [3:0] cnt;
  logic       dout;
  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  debounce_filter i_debounce_filter (
    .clk(clk), .rst_n(rst_n), .tick(tick), .din(din),
    .cfg_type(ftype), .cfg_long(lng), .cfg_coarse(crs), .cfg_count(cnt),
    .dout(dout)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000 && !done) begin
      errors++;
      $display("FAIL watchdog: actual cycles %0d expected below %0d", cyc, 190000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int unit_of(input logic l, input logic c);
    case ({l, c})
      2'b00:   return 2;
      2'b01:   return 8;
      2'b10:   return 512;
      default: return 2048;
    endcase
  endfunction

  function automatic bit is_filtered(input int ft, input logic rising);
    if (ft == 1) return 1'b1;
    if (ft == 2) return rising;
    if (ft == 3) return !rising;
    return 1'b0;
  endfunction

  // Bring dout to 'start' through pass-through, then load the configuration.
  task automatic setup(input int ft, input logic l, input logic c, input int n, input logic start);
    ftype = 2'd0; din = start;
    step(2);
    ftype = 2'(ft); lng = l; crs = c; cnt = 4'(n);
    step(2);
  endtask

  task automatic edge_case(input int ft, input logic l, input logic c, input int n, input logic rising);
    int t;
    setup(ft, l, c, n, !rising);
    t = (n == 0) ? 1 : n * unit_of(l, c);
    din = rising;
    if (is_filtered(ft, rising)) begin
      if (t > 1) begin
        step(t - 1);
        chk("R3 held before timeout", dout, !rising);
      end
      step(1);
      chk("R4 change at T-th tick", dout, rising);
    end else begin
      step(1);
      chk("R6 unfiltered direction next edge", dout, rising);
    end
  endtask

  initial begin
    rst_n = 1'b0; tick = 1'b1; din = 1'b1; ftype = 2'd0; lng = 1'b0; crs = 1'b0; cnt = 4'd0;
    step(3);
    chk("R1 output low in reset", dout, 1'b0);
    din = 1'b0;
    rst_n = 1'b1;
    step(1);
    chk("R1 output low after reset", dout, 1'b0);

    // R2: pass-through under several patterns.
    for (int p = 0; p < 16; p++) begin
      din = p[0] ^ p[2];
      step(1);
      chk("R2 off copies input", dout, p[0] ^ p[2]);
    end

    // R8: timing fields toggle while off; still a plain copy each edge.
    for (int p = 0; p < 12; p++) begin
      din = p[1]; cnt = 4'(p); lng = p[0]; crs = p[2];
      step(1);
      chk("R8 fields ignored while off", dout, p[1]);
    end

    // R3 / R4 / R6: sweep types, short units, all counts, both directions.
    for (int ft = 1; ft <= 3; ft++)
      for (int c = 0; c <= 1; c++)
        for (int n = 0; n <= 15; n++)
          for (int r = 0; r <= 1; r++)
            edge_case(ft, 1'b0, c[0], n, r[0]);

    // R4: long units.
    edge_case(1, 1'b1, 1'b0, 1, 1'b1);
    edge_case(2, 1'b1, 1'b0, 3, 1'b1);
    edge_case(3, 1'b1, 1'b1, 1, 1'b0);
    edge_case(1, 1'b1, 1'b1, 15, 1'b1);

    // R5: a short pulse is dropped; a later attempt needs the full timeout.
    for (int ft = 1; ft <= 3; ft++) begin
      logic rising;
      rising = (ft == 3) ? 1'b0 : 1'b1;
      setup(ft, 1'b0, 1'b0, 2, !rising);
      din = rising;
      step(3);
      din = !rising;
      step(9);
      chk("R5 short pulse dropped", dout, !rising);
      din = rising;
      step(3);
      chk("R5 full timeout needed again", dout, !rising);
      step(1);
      chk("R5 accepted after full timeout", dout, rising);
    end

    // R7: count change on the very edge that would complete (T=6 -> T=8).
    setup(1, 1'b0, 1'b0, 3, 1'b0);
    din = 1'b1;
    step(5);
    cnt = 4'd4;
    step(1);
    chk("R7 hold on change at expiry edge", dout, 1'b0);
    step(7);
    chk("R7 new timeout still running", dout, 1'b0);
    step(1);
    chk("R7 new timeout completes", dout, 1'b1);

    // R7: change together with an unfiltered change.
    setup(2, 1'b0, 1'b0, 5, 1'b1);
    din = 1'b0; cnt = 4'd6;
    step(1);
    chk("R7 hold on change with pass", dout, 1'b1);
    step(1);
    chk("R7 pass after change", dout, 1'b0);

    // R9: no ticks, no progress.
    setup(1, 1'b0, 1'b0, 2, 1'b0);
    tick = 1'b0;
    din = 1'b1;
    step(20);
    chk("R9 stalled without ticks", dout, 1'b0);
    tick = 1'b1;
    step(3);
    chk("R9 three ticks not enough", dout, 1'b0);
    step(1);
    chk("R9 fourth tick completes", dout, 1'b1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule